// File: doc/BRIEF.md
# Chained Watchpoint and Hit Counter Unit

This block turns a vector of eight per-event match flags into ten watchpoints. It does not compare addresses or data itself. A neighbouring comparator bank produces the match flags. Each cycle the block evaluates the watchpoints in ascending order. Each watchpoint either passes its own match, ANDs it with the watchpoint just below it, or ORs it with that watchpoint, as its 2-bit link field selects.

Two 16-bit hit counters sit on top of the chain. Every one of the lower eight watchpoints is assigned to one of the two counters. An enabled counter advances by the number of its assigned watchpoints that are active in the cycle. Watchpoints 8 and 9 are derived from the counters after that update: each is true when its counter's count equals its programmed limit. They then continue the same chain.

Every active watchpoint whose break-enable bit is set latches a sticky status bit and raises a breakpoint pulse. The surrounding debug logic uses the pulse to halt the core and reads the status bits to find the cause. The block does nothing in a cycle with no match flags set. It also does nothing while every break-enable bit and every counter-assignment bit is zero.

Top module: `wpc_unit`

## Requirements
- R1: Each watchpoint `i` has a link field at `link_cfg_i[2i+1:2i]`. Code 00 gives the watchpoint its own source. Code 01 gives its source AND watchpoint `i-1`. Code 10 gives its source OR watchpoint `i-1`. The source of watchpoints 0..7 is `match_i[i]`.
- R2: Link code 11 forces the watchpoint to 0. Watchpoint 0 has no lower neighbour, so codes 01 and 10 also force it to 0.
- R3: Watchpoints are evaluated in ascending order, so every link uses the value of watchpoint `i-1` computed in the same cycle. A chain can therefore ripple from watchpoint 0 up to watchpoint 9 in one cycle.
- R4: `cnt_sel_i[i]` assigns watchpoint `i` (0..7) to counter 0 when it is 0 and to counter 1 when it is 1. When its bit in `cnt_en_i` is set, a counter advances by the number of its assigned watchpoints that are active in an active cycle. A disabled counter holds its value.
- R5: Counts wrap modulo 2^16.
- R6: The source of watchpoint 8 is "counter 0 count equals its limit" and the source of watchpoint 9 is the same test on counter 1. Both use the counter values after this cycle's update. They link to watchpoint 7 and watchpoint 8 respectively.
- R7: In an active cycle, every watchpoint that is true and has its `brk_en_i` bit set sets its bit in `sts_o`. In that case `brk_o` is high in the following cycle. Otherwise `brk_o` is low in the following cycle.
- R8: Status bits are sticky. They change only through `sts_wr_i`, which loads `sts_wdata_i`. Hits in the same cycle are still ORed on top of the loaded value.
- R9: A cycle is active only when `match_i` is non-zero and at least one `brk_en_i` or `cnt_sel_i` bit is set. An inactive cycle changes neither counter nor any status bit, and is followed by `brk_o` low.
- R10: `cnt_wr_i[k]` loads counter `k` from `cnt_wdata_i`: bits 15:0 are the count and bits 31:16 are the limit. A load takes priority over that counter's increment in the same cycle. The counter state is readable on `cnt_o`, with counter `k` at bits `[32k+31:32k]` in the same layout.
- R11: After synchronous reset, counters, status and `brk_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| match_i | input | 8 | Per-event match flags from the comparator bank |
| link_cfg_i | input | 20 | 2-bit link field per watchpoint |
| brk_en_i | input | 10 | Break enable per watchpoint |
| cnt_sel_i | input | 8 | Counter assignment for watchpoints 0..7 |
| cnt_en_i | input | 2 | Counter enables |
| cnt_wr_i | input | 2 | Counter load strobes |
| cnt_wdata_i | input | 32 | Load value: limit in bits 31:16, count in bits 15:0 |
| cnt_o | output | 64 | Counter state, two 32-bit words |
| sts_wr_i | input | 1 | Status load strobe |
| sts_wdata_i | input | 10 | Status load value |
| sts_o | output | 10 | Sticky break status |
| brk_o | output | 1 | Breakpoint pulse, one cycle after the causing event |

## Verification
All 256 match vectors are swept under uniform link settings (all pass, all AND, all OR, all reserved). This separates each link mode and shows how far an AND or OR chain ripples. Mixed and pseudo-random link settings catch indexing slips between neighbouring fields. The same sweeps run again with a counter limit of zero, so that watchpoints 8 and 9 have a true source. A further sweep with both counters enabled and a split assignment checks the counts against a computed per-counter population count, a load just below 2^16 checks the wrap, and a counter load in the same cycle as a hit checks that the load wins. Short sequences cover sticky status, the status load, partial break enables and both idle conditions.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

    localparam int NUM_CNT = 2;

    typedef enum logic [1:0] {
        LINK_SOLO = 2'b00,
        LINK_AND  = 2'b01,
        LINK_OR   = 2'b10,
        LINK_RSVD = 2'b11
    } link_e;

    // Combine a watchpoint source with the watchpoint below it.
    function automatic logic link_apply(input link_e mode, input logic src,
                                        input logic below, input logic has_below);
        case (mode)
            LINK_SOLO: return src;
            LINK_AND:  return has_below & src & below;
            LINK_OR:   return has_below & (src | below);
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/wpc_chain.sv
module wpc_chain
    import wpc_pkg::*;
#(
    parameter int NMP = 8
) (
    input  logic [NMP-1:0]   match_i,
    input  logic [2*NMP-1:0] link_i,
    output logic [NMP-1:0]   wp_o
);

    logic carry;

    // Ascending evaluation: each stage sees the fresh value of the stage below.
    always_comb begin
        carry = 1'b0;
        for (int i = 0; i < NMP; i++) begin
            wp_o[i] = link_apply(link_e'(link_i[2*i +: 2]), match_i[i], carry, i != 0);
            carry   = wp_o[i];
        end
    end

endmodule

// File: rtl/wpc_counter.sv
module wpc_counter #(
    parameter int NMP = 8,
    parameter int CW  = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            act_i,
    input  logic            en_i,
    input  logic [NMP-1:0]  own_i,
    input  logic            wr_i,
    input  logic [2*CW-1:0] wdata_i,
    output logic [2*CW-1:0] reg_o,
    output logic            hit_o
);

    localparam int SW = $clog2(NMP + 1);

    logic [SW-1:0] step;
    logic [CW-1:0] cnt_q, cnt_d, lim_q, lim_d;

    always_comb begin
        step = '0;
        for (int i = 0; i < NMP; i++)
            step = step + SW'(own_i[i]);
    end

    always_comb begin
        cnt_d = cnt_q;
        lim_d = lim_q;
        if (wr_i) begin
            cnt_d = wdata_i[CW-1:0];
            lim_d = wdata_i[2*CW-1:CW];
        end else if (act_i && en_i) begin
            cnt_d = cnt_q + CW'(step);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            lim_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            lim_q <= lim_d;
        end
    end

    // The comparison sees the post-update count.
    assign hit_o = (cnt_d == lim_d);
    assign reg_o = {lim_q, cnt_q};

    // R4: without a load, one cycle never advances a count by more than NMP.
    p_step_bound_r4: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> (CW'(cnt_q - $past(cnt_q)) <= CW'(NMP)));

    // R10: the limit changes only through a load.
    p_limit_load_r10: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> $stable(lim_q));

endmodule

// File: rtl/wpc_status.sv
module wpc_status #(
    parameter int NWP = 10
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           act_i,
    input  logic [NWP-1:0] wp_i,
    input  logic [NWP-1:0] en_i,
    input  logic           wr_i,
    input  logic [NWP-1:0] wdata_i,
    output logic [NWP-1:0] sts_o,
    output logic           brk_o
);

    logic [NWP-1:0] fire, sts_q;
    logic           brk_q;

    assign fire = act_i ? (wp_i & en_i) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q <= '0;
            brk_q <= 1'b0;
        end else begin
            sts_q <= (wr_i ? wdata_i : sts_q) | fire;
            brk_q <= |fire;
        end
    end

    assign sts_o = sts_q;
    assign brk_o = brk_q;

    // R8: without a load, no status bit ever clears.
    p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> ((sts_q & $past(sts_q)) == $past(sts_q)));

    // R7: a pulse always comes with a recorded cause.
    p_brk_has_cause_r7: assert property (@(posedge clk) disable iff (rst)
        brk_q |-> (sts_q != '0));

endmodule

// File: rtl/wpc_unit.sv
module wpc_unit
    import wpc_pkg::*;
#(
    parameter int NMP = 8,
    parameter int CW  = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NMP-1:0]            match_i,
    input  logic [2*(NMP+NUM_CNT)-1:0] link_cfg_i,
    input  logic [NMP+NUM_CNT-1:0]    brk_en_i,
    input  logic [NMP-1:0]            cnt_sel_i,
    input  logic [NUM_CNT-1:0]        cnt_en_i,
    input  logic [NUM_CNT-1:0]        cnt_wr_i,
    input  logic [2*CW-1:0]           cnt_wdata_i,
    output logic [NUM_CNT*2*CW-1:0]   cnt_o,
    input  logic                      sts_wr_i,
    input  logic [NMP+NUM_CNT-1:0]    sts_wdata_i,
    output logic [NMP+NUM_CNT-1:0]    sts_o,
    output logic                      brk_o
);

    localparam int NWP = NMP + NUM_CNT;

    logic               act;
    logic [NMP-1:0]     wp_lo;
    logic [NUM_CNT-1:0] cnt_hit;
    logic [NWP-1:0]     wp;
    logic               carry_hi;

    assign act = (|match_i) && ((|brk_en_i) || (|cnt_sel_i));

    wpc_chain #(.NMP(NMP)) chain_i (
        .match_i (match_i),
        .link_i  (link_cfg_i[2*NMP-1:0]),
        .wp_o    (wp_lo)
    );

    for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
        logic [NMP-1:0] own;
        if (k == 0) begin : g_sel0
            assign own = wp_lo & ~cnt_sel_i;
        end else begin : g_sel1
            assign own = wp_lo & cnt_sel_i;
        end

        wpc_counter #(.NMP(NMP), .CW(CW)) cnt_i (
            .clk     (clk),
            .rst     (rst),
            .act_i   (act),
            .en_i    (cnt_en_i[k]),
            .own_i   (own),
            .wr_i    (cnt_wr_i[k]),
            .wdata_i (cnt_wdata_i),
            .reg_o   (cnt_o[k*2*CW +: 2*CW]),
            .hit_o   (cnt_hit[k])
        );
    end

    // Counter-derived watchpoints continue the chain above watchpoint NMP-1.
    always_comb begin
        wp[NMP-1:0] = wp_lo;
        carry_hi    = wp_lo[NMP-1];
        for (int k = 0; k < NUM_CNT; k++) begin
            wp[NMP+k] = link_apply(link_e'(link_cfg_i[2*(NMP+k) +: 2]),
                                   cnt_hit[k], carry_hi, 1'b1);
            carry_hi  = wp[NMP+k];
        end
    end

    wpc_status #(.NWP(NWP)) status_i (
        .clk     (clk),
        .rst     (rst),
        .act_i   (act),
        .wp_i    (wp),
        .en_i    (brk_en_i),
        .wr_i    (sts_wr_i),
        .wdata_i (sts_wdata_i),
        .sts_o   (sts_o),
        .brk_o   (brk_o)
    );

    // R2: a reserved link code never yields an active watchpoint.
    for (genvar i = 0; i < NWP; i++) begin : g_rsvd_chk
        p_rsvd_off_r2: assert property (@(posedge clk) disable iff (rst)
            (link_cfg_i[2*i +: 2] == 2'b11) |-> !wp[i]);
    end

    // R2: the lowest watchpoint cannot link downward.
    p_wp0_solo_r2: assert property (@(posedge clk) disable iff (rst)
        (link_cfg_i[1:0] != 2'b00) |-> !wp[0]);

    // R9: an idle cycle is never followed by a pulse.
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !act |=> !brk_o);

    // R9: an idle cycle without loads leaves the counters untouched.
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!act && (cnt_wr_i == '0)) |=> $stable(cnt_o));

endmodule

// File: tb/wpc_unit_tb_top.sv
module wpc_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  match_i;
    logic [19:0] link_cfg_i;
    logic [9:0]  brk_en_i;
    logic [7:0]  cnt_sel_i;
    logic [1:0]  cnt_en_i;
    logic [1:0]  cnt_wr_i;
    logic [31:0] cnt_wdata_i;
    logic [63:0] cnt_o;
    logic        sts_wr_i;
    logic [9:0]  sts_wdata_i;
    logic [9:0]  sts_o;
    logic        brk_o;

    int n_checks = 0;
    int n_fail   = 0;

    logic [15:0] m_cnt [2];
    logic [15:0] m_lim [2];
    logic [9:0]  m_sts;
    logic        m_brk;

    always #10 clk = ~clk;

    wpc_unit dut_i (
        .clk (clk), .rst (rst), .match_i (match_i), .link_cfg_i (link_cfg_i),
        .brk_en_i (brk_en_i), .cnt_sel_i (cnt_sel_i), .cnt_en_i (cnt_en_i),
        .cnt_wr_i (cnt_wr_i), .cnt_wdata_i (cnt_wdata_i), .cnt_o (cnt_o),
        .sts_wr_i (sts_wr_i), .sts_wdata_i (sts_wdata_i), .sts_o (sts_o),
        .brk_o (brk_o)
    );

    function automatic logic link_ref(input logic [1:0] code, input logic src,
                                      input logic below, input bit first);
        if (code == 2'd0) return src;
        if (code == 2'd3 || first) return 1'b0;
        if (code == 2'd1) return src && below;
        return src || below;
    endfunction

    function automatic int popc(input logic [7:0] v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += int'(v[i]);
        return n;
    endfunction

    // Drive one cycle at a falling edge, update the model, sample at the next falling edge.
    task automatic step(input logic [7:0] mp, input logic [1:0] cwr,
                        input logic [31:0] cwd, input logic swr,
                        input logic [9:0] swd, input string tag);
        logic [9:0] w;
        logic       act, h;
        logic [63:0] exp_cnt;
        match_i = mp; cnt_wr_i = cwr; cnt_wdata_i = cwd;
        sts_wr_i = swr; sts_wdata_i = swd;
        act = (mp != 0) && ((brk_en_i != 0) || (cnt_sel_i != 0));
        for (int i = 0; i < 8; i++)
            w[i] = link_ref(link_cfg_i[2*i +: 2], mp[i], (i == 0) ? 1'b0 : w[(i == 0) ? 0 : i-1], i == 0);
        for (int k = 0; k < 2; k++) begin
            if (cwr[k]) begin
                m_cnt[k] = cwd[15:0];
                m_lim[k] = cwd[31:16];
            end else if (act && cnt_en_i[k]) begin
                m_cnt[k] = m_cnt[k] + 16'(popc(w[7:0] & (k == 0 ? ~cnt_sel_i : cnt_sel_i)));
            end
        end
        for (int k = 0; k < 2; k++) begin
            h = (m_cnt[k] == m_lim[k]);
            w[8+k] = link_ref(link_cfg_i[2*(8+k) +: 2], h, w[7+k], 1'b0);
        end
        m_sts = (swr ? swd : m_sts) | (act ? (w & brk_en_i) : 10'd0);
        m_brk = act && ((w & brk_en_i) != 0);
        exp_cnt = {m_lim[1], m_cnt[1], m_lim[0], m_cnt[0]};
        @(negedge clk);
        n_checks++;
        if (sts_o !== m_sts || brk_o !== m_brk || cnt_o !== exp_cnt) begin
            n_fail++;
            $display("FAIL %s mp=%h link=%h: sts=%h brk=%b cnt=%h expected sts=%h brk=%b cnt=%h",
                     tag, mp, link_cfg_i, sts_o, brk_o, cnt_o, m_sts, m_brk, exp_cnt);
        end
    endtask

    task automatic sweep(input logic [19:0] link, input string tag);
        link_cfg_i = link;
        for (int v = 0; v < 256; v++) step(8'(v), 2'b00, 32'h0, 1'b1, 10'h0, tag);
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        rst = 1'b1; match_i = '0; link_cfg_i = '0; brk_en_i = '0; cnt_sel_i = '0;
        cnt_en_i = '0; cnt_wr_i = '0; cnt_wdata_i = '0; sts_wr_i = 1'b0; sts_wdata_i = '0;
        m_cnt[0] = '0; m_cnt[1] = '0; m_lim[0] = '0; m_lim[1] = '0; m_sts = '0; m_brk = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        n_checks++;
        if (sts_o !== 10'h0 || brk_o !== 1'b0 || cnt_o !== 64'h0) begin
            n_fail++;
            $display("FAIL R11 reset: sts=%h brk=%b cnt=%h expected all zero", sts_o, brk_o, cnt_o);
        end

        // Chain sweeps with counters disabled; limit 5 (source false), then limit 0 (source true).
        brk_en_i = 10'h3FF;
        for (int pre = 0; pre < 2; pre++) begin
            step(8'h0, 2'b11, (pre == 0) ? 32'h0005_0000 : 32'h0, 1'b1, 10'h0, "R10");
            sweep(20'h00000, "R1");
            sweep(20'h55555, "R3");
            sweep(20'hAAAAA, "R3");
            sweep(20'hFFFFF, "R2");
            sweep(20'h55554, "R1");
            sweep(20'hAAAA8, "R6");
            sweep(20'h9C6E4, "R1");
            sweep(20'h6B1D2, "R2");
            seed = 32'h1234_5678;
            for (int r = 0; r < 4; r++) begin
                seed = seed * 32'd1103515245 + 32'd12345;
                sweep(seed[27:8], "R3");
            end
        end

        // Counter sweep: split assignment, both enabled, no break enables.
        brk_en_i = '0; cnt_sel_i = 8'hA5; cnt_en_i = 2'b11; link_cfg_i = 20'h0;
        step(8'h0, 2'b11, 32'h0028_0000, 1'b0, 10'h0, "R10");
        for (int v = 0; v < 256; v++) step(8'(v), 2'b00, 32'h0, 1'b0, 10'h0, "R4");
        cnt_en_i = 2'b01;
        for (int v = 0; v < 64; v++) step(8'(v * 3 + 1), 2'b00, 32'h0, 1'b0, 10'h0, "R4");

        // R5: wrap
        cnt_sel_i = 8'h01; cnt_en_i = 2'b11;
        step(8'h0, 2'b01, 32'h0006_FFFE, 1'b0, 10'h0, "R10");
        step(8'hFF, 2'b00, 32'h0, 1'b0, 10'h0, "R5");
        // R10: load beats increment
        step(8'hFF, 2'b11, 32'h0003_0003, 1'b0, 10'h0, "R10");

        // R9: idle with no enables and no assignment
        cnt_sel_i = 8'h00; brk_en_i = '0;
        step(8'hFF, 2'b00, 32'h0, 1'b0, 10'h0, "R9");
        // R9: idle with zero match vector
        brk_en_i = 10'h3FF;
        step(8'h00, 2'b00, 32'h0, 1'b0, 10'h0, "R9");

        // R7/R8: sticky status and load
        cnt_en_i = 2'b00;
        step(8'h00, 2'b11, 32'h0009_0000, 1'b1, 10'h0, "R8");
        step(8'h01, 2'b00, 32'h0, 1'b0, 10'h0, "R7");
        step(8'h00, 2'b00, 32'h0, 1'b0, 10'h0, "R8");
        step(8'h80, 2'b00, 32'h0, 1'b0, 10'h0, "R8");
        step(8'h04, 2'b00, 32'h0, 1'b1, 10'h000, "R8");
        step(8'h00, 2'b00, 32'h0, 1'b1, 10'h2A5, "R8");

        // R7: partial break enables
        brk_en_i = 10'h0A5; link_cfg_i = 20'h0;
        for (int v = 0; v < 256; v++) step(8'(v), 2'b00, 32'h0, 1'b1, 10'h0, "R7");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule